// File: doc/BRIEF.md
# Serial Input Conditioning Stage

This block prepares one serial input line for a communication channel. It picks the raw source from seven external pins or a constant high level, brings the chosen level into the module clock domain through a two-flop synchronizer, and can pass it through a small digital glitch filter. It can then invert the level. The result, or an alternate internal path that is already synchronous, is registered as the channel's data value.

A programmable edge detector watches that data value. It emits a one-clock trigger pulse on rising edges, falling edges, both edges, or never. A single control word sets all options. The raw synchronized level, taken before filtering and inversion, is available as a separate status bit.

Top module: `serial_input_selector`

## Requirements
- R1: While `rstN` is low and on the first cycle after its release, `dataOut`, `syncStatus` and `trigPulse` are all 0.
- R2: `ctrlWord[2:0]` codes 0 through 6 select `padIn[0]` through `padIn[6]`. With the filter, inversion and alternate path off, a change on the selected pin appears on `dataOut` three clock edges after it is applied.
- R3: Source code 7 forces the selected level to a constant 1, whatever the pins carry.
- R4: `syncStatus` shows the selected raw level two clock edges after it changes. Inversion and the filter do not affect it.
- R5: `ctrlWord[3]` = 1 inverts the selected level before it reaches `dataOut`.
- R6: With `ctrlWord[4]` = 1 (filter on), a new level held for fewer than three consecutive sample ticks never reaches `dataOut`.
- R7: With the filter on and `ctrlWord[5]` = 1 (a sample tick every clock), a level held steadily appears on `dataOut` six clock edges after it is applied.
- R8: With `ctrlWord[5]` = 0, sample ticks come once every 4 clocks. A 6-clock pulse is rejected, and a level held for 20 clocks is accepted.
- R9: Trigger mode `ctrlWord[7:6]` = 0 produces no trigger pulses.
- R10: Mode 1 pulses `trigPulse` for exactly one clock, in the same cycle that `dataOut` rises, and never on a fall.
- R11: Mode 2 pulses `trigPulse` for one clock when `dataOut` falls, and never on a rise.
- R12: Mode 3 pulses on both edges. Any trigger pulse coincides with a change of `dataOut`.
- R13: Edges are judged after inversion. In mode 1 with inversion on, a falling pin produces the pulse.
- R14: `ctrlWord[8]` = 1 feeds `altIn` to `dataOut` after one clock edge and ignores the pins. Triggers follow `altIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| padIn | input | 7 | Asynchronous candidate pins |
| altIn | input | 1 | Alternate internal path, synchronous to clk |
| ctrlWord | input | 9 | Control word: source, inversion, filter, tick rate, trigger mode, path switch |
| dataOut | output | 1 | Conditioned channel data value |
| syncStatus | output | 1 | Synchronized raw selected level |
| trigPulse | output | 1 | One-clock edge trigger |

## Verification
The assertions take `altIn` to be synchronous to `clk`. They also take `ctrlWord` as configuration that software changes only occasionally, not in every cycle. A change of source or polarity can itself produce an edge, and the assertions accept that edge as legitimate. The stimulus changes `ctrlWord` only while the selected level is settled, then waits several clocks before judging any output. It drives pins and `altIn` just after a rising edge, so their timing relative to the synchronizer is exact.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef struct packed {
    logic       sampleTick;
    logic       invert;
    logic       filtEn;
    logic       useAlt;
    logic       riseEn;
    logic       fallEn;
    logic [2:0] srcSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/sis_ctrl.sv
module sis_ctrl #(
  parameter int SEL_W    = 3,
  parameter int SLOW_DIV = 4,
  parameter int CTRL_W   = SEL_W + 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CTRL_W-1:0]    ctrlWord,
  output sis_pkg::ctrlStrobe_t strobes
);
  localparam int DIV_W   = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int B_INV   = SEL_W;
  localparam int B_FILT  = SEL_W + 1;
  localparam int B_FAST  = SEL_W + 2;
  localparam int B_MODE  = SEL_W + 3;
  localparam int B_ALT   = SEL_W + 5;

  logic [DIV_W-1:0] divCnt;
  logic             slowTick;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (divCnt == DIV_W'(SLOW_DIV - 1)) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  assign slowTick = (divCnt == DIV_W'(SLOW_DIV - 1));

  always_comb begin
    strobes.srcSel     = ctrlWord[2:0];
    strobes.invert     = ctrlWord[B_INV];
    strobes.filtEn     = ctrlWord[B_FILT];
    strobes.sampleTick = ctrlWord[B_FAST] | slowTick;
    strobes.riseEn     = ctrlWord[B_MODE];
    strobes.fallEn     = ctrlWord[B_MODE+1];
    strobes.useAlt     = ctrlWord[B_ALT];
  end

  // R8: in slow mode two ticks are never adjacent
  a_r8_slow_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (slowTick && !ctrlWord[B_FAST]) |=> !slowTick);
endmodule

// File: rtl/sis_datapath.sv
module sis_datapath #(
  parameter int N_PADS = 7,
  parameter int STABLE = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [N_PADS-1:0]    padIn,
  input  logic                 altIn,
  input  sis_pkg::ctrlStrobe_t strobes,
  output logic                 dataOut,
  output logic                 syncStatus,
  output logic                 trigPulse
);
  localparam int CNT_W = (STABLE > 1) ? $clog2(STABLE) : 1;

  logic             rawSel;
  logic             s1, s2;
  logic             filtLvl;
  logic [CNT_W-1:0] stableCnt;
  logic             stageVal, chanVal, dataQ, trigQ;

  always_comb begin
    rawSel = 1'b1;
    for (int i = 0; i < N_PADS; i++)
      if (32'(strobes.srcSel) == i) rawSel = padIn[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= rawSel;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtLvl   <= 1'b0;
      stableCnt <= '0;
    end else if (strobes.sampleTick) begin
      if (s2 == filtLvl) stableCnt <= '0;
      else if (stableCnt == CNT_W'(STABLE - 1)) begin
        filtLvl   <= s2;
        stableCnt <= '0;
      end else stableCnt <= stableCnt + 1'b1;
    end
  end

  assign stageVal = (strobes.filtEn ? filtLvl : s2) ^ strobes.invert;
  assign chanVal  = strobes.useAlt ? altIn : stageVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= 1'b0;
      trigQ <= 1'b0;
    end else begin
      dataQ <= chanVal;
      trigQ <= (chanVal & ~dataQ & strobes.riseEn) |
               (~chanVal & dataQ & strobes.fallEn);
    end
  end

  assign dataOut    = dataQ;
  assign syncStatus = s2;
  assign trigPulse  = trigQ;

  // R6: filter state only moves on a sample tick
  a_r6_filter_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.sampleTick |=> $stable(filtLvl));
  // R9: a disabled trigger mode yields no pulse
  a_r9_no_trig_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.riseEn && !strobes.fallEn) |=> !trigPulse);
  // R10: rising-only mode pulses only on a high level
  a_r10_rise_only: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && !$past(strobes.fallEn)) |-> dataOut);
  // R11: falling-only mode pulses only on a low level
  a_r11_fall_only: assert property (@(posedge clk) disable iff (!rstN)
    (trigPulse && !$past(strobes.riseEn)) |-> !dataOut);
  // R12: every pulse coincides with a data change
  a_r12_trig_on_change: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> (dataOut != $past(dataOut)));
endmodule

// File: rtl/serial_input_selector.sv
module serial_input_selector #(
  parameter int N_PADS   = 7,
  parameter int SLOW_DIV = 4,
  parameter int STABLE   = 3,
  parameter int SEL_W    = 3,
  parameter int CTRL_W   = SEL_W + 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [N_PADS-1:0] padIn,
  input  logic              altIn,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic              dataOut,
  output logic              syncStatus,
  output logic              trigPulse
);
  sis_pkg::ctrlStrobe_t strobes;

  sis_ctrl #(.SEL_W(SEL_W), .SLOW_DIV(SLOW_DIV), .CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .strobes(strobes));

  sis_datapath #(.N_PADS(N_PADS), .STABLE(STABLE)) u_datapath (
    .clk(clk), .rstN(rstN), .padIn(padIn), .altIn(altIn), .strobes(strobes),
    .dataOut(dataOut), .syncStatus(syncStatus), .trigPulse(trigPulse));

  // R1: quiet outputs right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!dataOut && !syncStatus && !trigPulse));
endmodule

// File: tb/serial_input_selector_bench.sv
`timescale 1ns/1ps
module serial_input_selector_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] padIn = '0;
  logic       altIn = 1'b0;
  logic [8:0] ctrlWord = '0;
  logic       dataOut, syncStatus, trigPulse;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  typedef struct {
    string      req;
    logic [2:0] exp;   // {dataOut, syncStatus, trigPulse}
    logic [2:0] mask;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  serial_input_selector u_serial_input_selector (
    .clk(clk), .rstN(rstN), .padIn(padIn), .altIn(altIn), .ctrlWord(ctrlWord),
    .dataOut(dataOut), .syncStatus(syncStatus), .trigPulse(trigPulse));

  function automatic logic [8:0] mkCtrl(input int sel, input bit inv, input bit filt,
                                        input bit fast, input int mode, input bit alt);
    return {alt, 2'(mode), fast, filt, inv, 3'(sel)};
  endfunction

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic expectOut(input string req, input logic [2:0] exp, input logic [2:0] mask);
    item_t it;
    it.req = req; it.exp = exp; it.mask = mask;
    sb.push_back(it);
  endtask

  task automatic setCtrl(input logic [8:0] c);
    ctrlWord = c;
    step(10);
  endtask

  // monitor: compares queued expectations away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [2:0] got;
        it  = sb.pop_front();
        got = {dataOut, syncStatus, trigPulse};
        checks++;
        if ((got & it.mask) !== (it.exp & it.mask)) begin
          failures++;
          $display("FAIL %s: got %b expected %b (mask %b)", it.req, got, it.exp, it.mask);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ctrlWord = mkCtrl(0, 0, 0, 1, 0, 0);
    step(3);
    expectOut("R1", 3'b000, 3'b111);
    rstN = 1'b1;
    step(1);
    expectOut("R1", 3'b000, 3'b111);

    // R2 select each pin
    for (int i = 0; i < 7; i++) begin
      padIn = '0;
      setCtrl(mkCtrl(i, 0, 0, 1, 0, 0));
      padIn = 7'(1 << i);
      step(2);
      expectOut("R2", 3'b000, 3'b100);
      step(1);
      expectOut("R2", 3'b100, 3'b100);
      padIn = ~7'(1 << i);
      step(3);
      expectOut("R2", 3'b000, 3'b100);
    end

    // R3 constant one
    padIn = '0;
    setCtrl(mkCtrl(7, 0, 0, 1, 0, 0));
    expectOut("R3", 3'b110, 3'b110);

    // R4 / R5 sync status and inversion
    padIn = '0;
    setCtrl(mkCtrl(0, 1, 0, 1, 0, 0));
    expectOut("R5", 3'b100, 3'b110);
    padIn[0] = 1'b1;
    step(2);
    expectOut("R4", 3'b110, 3'b110);
    step(1);
    expectOut("R5", 3'b010, 3'b110);

    // R6 / R7 fast filter
    padIn = '0;
    setCtrl(mkCtrl(0, 0, 1, 1, 0, 0));
    expectOut("R6", 3'b000, 3'b100);
    padIn[0] = 1'b1; step(2); padIn[0] = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      expectOut("R6", 3'b000, 3'b100);
    end
    padIn[0] = 1'b1;
    step(5);
    expectOut("R7", 3'b000, 3'b100);
    step(1);
    expectOut("R7", 3'b100, 3'b100);

    // R8 slow filter
    padIn = '0;
    setCtrl(mkCtrl(0, 0, 1, 0, 0, 0));
    step(20);
    expectOut("R8", 3'b000, 3'b100);
    padIn[0] = 1'b1; step(6); padIn[0] = 1'b0;
    step(20);
    expectOut("R8", 3'b000, 3'b100);
    padIn[0] = 1'b1;
    step(20);
    expectOut("R8", 3'b100, 3'b100);

    // R9 trigger disabled
    padIn = '0;
    setCtrl(mkCtrl(0, 0, 0, 1, 0, 0));
    padIn[0] = 1'b1; step(3);
    expectOut("R9", 3'b100, 3'b101);
    padIn[0] = 1'b0; step(3);
    expectOut("R9", 3'b000, 3'b101);

    // R10 rising
    setCtrl(mkCtrl(0, 0, 0, 1, 1, 0));
    padIn[0] = 1'b1; step(3);
    expectOut("R10", 3'b101, 3'b101);
    step(1);
    expectOut("R10", 3'b100, 3'b101);
    padIn[0] = 1'b0; step(3);
    expectOut("R10", 3'b000, 3'b101);

    // R11 falling
    setCtrl(mkCtrl(0, 0, 0, 1, 2, 0));
    padIn[0] = 1'b1; step(3);
    expectOut("R11", 3'b100, 3'b101);
    padIn[0] = 1'b0; step(3);
    expectOut("R11", 3'b001, 3'b101);
    step(1);
    expectOut("R11", 3'b000, 3'b101);

    // R12 both edges
    setCtrl(mkCtrl(0, 0, 0, 1, 3, 0));
    padIn[0] = 1'b1; step(3);
    expectOut("R12", 3'b101, 3'b101);
    padIn[0] = 1'b0; step(3);
    expectOut("R12", 3'b001, 3'b101);

    // R13 rising after inversion
    setCtrl(mkCtrl(0, 1, 0, 1, 1, 0));
    padIn[0] = 1'b1; step(3);
    expectOut("R13", 3'b000, 3'b101);
    padIn[0] = 1'b0; step(3);
    expectOut("R13", 3'b101, 3'b101);

    // R14 alternate path
    padIn = 7'h7f; altIn = 1'b0;
    setCtrl(mkCtrl(0, 0, 0, 1, 3, 1));
    expectOut("R14", 3'b000, 3'b101);
    padIn = '0; step(3);
    expectOut("R14", 3'b000, 3'b101);
    altIn = 1'b1; step(1);
    expectOut("R14", 3'b101, 3'b101);
    step(1);
    expectOut("R14", 3'b100, 3'b101);

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule